// File: doc/BRIEF.md
# Codec Register Access Bridge

This block sits on the host side of a serial audio codec link. Software uses it to read and write the codec's 16-bit internal registers. Three word-aligned registers are visible: a host control register, a command register and a data register. A command names a codec register and a direction. The bridge turns it into one request/response transaction on a simple codec port and holds a busy flag until that transaction has finished.

The host control register drives the link's reset and enable lines. It also shows three status bits: the link is up, a codec is present, and the link has failed. If a command arrives while the link is not up, the command finishes at once without touching the codec port. A one-cycle error pulse is raised for the interrupt logic.

Host register reads are combinational on the offset. Host writes take effect on the clock edge where the write enable is high.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset, the host control register reads 0x0000_8000 (reset bit 15 set, enable bit 14 clear, status clear). The command and data registers read 0, `codecReq` is low, `linkRstOut` is high and `linkEnOut` is low.
- R2: The command register reads busy at bit 15, direction at bit 7 and the 7-bit codec address at bits 6:0. All other bits read 0. Busy is 1 from the edge that accepts a command until the command completes.
- R3: A command written with bit 7 = 0 starts a write. `codecReq` rises with `codecRnw` = 0, `codecAddr` set to the command's bits 6:0 and `codecWrData` set to the data register. These values stay stable until `codecAck`.
- R4: A command written with bit 7 = 1 starts a read. `codecRdData` is captured on the `codecAck` cycle, and after busy clears the data register returns that value in bits 15:0.
- R5: `codecReq` is held until `codecAck` is sampled high and drops on the next edge. Busy stays 1 for exactly one further cycle after the ack cycle, then reads 0.
- R6: A command write that arrives while busy is set is ignored. The running transaction keeps its address and direction, and no second transaction is started.
- R7: A data register write that arrives while busy is set is ignored, so an in-flight write sends the value loaded beforehand.
- R8: Host control bit 15 holds the link in reset (`linkRstOut` = 1, `linkEnOut` = 0) and takes priority over bit 14. Writing bit 14 alone releases reset and drives `linkEnOut` high.
- R9: Host control status is as follows. Bit 0 is the link-up state (enabled, out of reset and `linkReadyIn` high). Bit 1 mirrors `codecFoundIn` and bit 2 mirrors `linkFailIn`.
- R10: A command accepted while the link is not up never raises `codecReq`. Busy reads 1 for one cycle only. A read loads 0 into the data register, and `linkErrPulse` is high for exactly one cycle.
- R11: Host control is at offset 0x00, command at 0x18 and data at 0x1C. Any other offset reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 8 | Host register byte offset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data for `hostAddr` |
| linkRstOut | output | 1 | Link reset line |
| linkEnOut | output | 1 | Link enable line |
| linkReadyIn | input | 1 | Link reports ready |
| codecFoundIn | input | 1 | Link reports a codec present |
| linkFailIn | input | 1 | Link reports a failure |
| codecReq | output | 1 | Transaction request to the codec port |
| codecRnw | output | 1 | 1 = read, 0 = write |
| codecAddr | output | 7 | Codec register address |
| codecWrData | output | 16 | Codec write data |
| codecAck | input | 1 | Codec port completion |
| codecRdData | input | 16 | Codec read data, valid with ack |
| linkErrPulse | output | 1 | One-cycle pulse when a command meets a link that is down |

## Verification
A wrong phase in the sequencer shows at the codec port on the next clock. A stuck request, a request that never rose, or a busy bit that stays set one cycle too long or too short is visible that way. The bench's per-clock reference catches it at once. A corrupted address, direction or data register shows either as a changed value on `codecAddr`/`codecWrData` while a request is open, or as a wrong value read back from the data register as soon as busy clears. Link-control state errors appear directly on `linkRstOut`, `linkEnOut` and status bit 0 in the cycle after the host write.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;

  // Bit positions decoded by software; kept fixed.
  localparam int BUSY_BIT = 15;
  localparam int DIR_BIT  = 7;
  localparam int RST_BIT  = 15;
  localparam int EN_BIT   = 14;
  localparam int UP_BIT   = 0;
  localparam int FOUND_BIT = 1;
  localparam int FAIL_BIT = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic accept;    // command taken this edge
    logic capRead;   // codec ack this edge
    logic zeroRead;  // command met a link that is down
    logic busy;      // transaction in progress
  } strobe_t;

endpackage

// File: rtl/codec_bridge_ctrl.sv
module codec_bridge_ctrl
  import codec_bridge_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdHit,
  input  logic    linkUp,
  input  logic    codecAck,
  output strobe_t strb,
  output logic    codecReq,
  output logic    linkErr
);

  phase_e phase, phaseNext;
  logic   accept;

  assign accept = cmdHit && (phase == PH_IDLE);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: if (accept) phaseNext = linkUp ? PH_WAIT : PH_DONE;
      PH_WAIT: if (codecAck) phaseNext = PH_DONE;
      PH_DONE: phaseNext = PH_IDLE;
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      linkErr <= 1'b0;
    end else begin
      phase   <= phaseNext;
      linkErr <= accept && !linkUp;
    end
  end

  always_comb begin
    strb.accept   = accept;
    strb.capRead  = (phase == PH_WAIT) && codecAck;
    strb.zeroRead = accept && !linkUp;
    strb.busy     = (phase != PH_IDLE);
  end

  assign codecReq = (phase == PH_WAIT);

endmodule

// File: rtl/codec_bridge_dp.sv
module codec_bridge_dp
  import codec_bridge_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int HDATA_W = 32,
  parameter int CREG_AW = 7,
  parameter int CDATA_W = 16,
  parameter logic [ADDR_W-1:0] OFF_CTRL = 'h00,
  parameter logic [ADDR_W-1:0] OFF_CMD  = 'h18,
  parameter logic [ADDR_W-1:0] OFF_DATA = 'h1C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic               hostWrEn,
  input  logic [HDATA_W-1:0] hostWrData,
  output logic [HDATA_W-1:0] hostRdData,
  input  strobe_t            strb,
  input  logic [CDATA_W-1:0] codecRdData,
  input  logic               linkReadyIn,
  input  logic               codecFoundIn,
  input  logic               linkFailIn,
  output logic               cmdHit,
  output logic               linkUp,
  output logic               linkRstOut,
  output logic               linkEnOut,
  output logic               codecRnw,
  output logic [CREG_AW-1:0] codecAddr,
  output logic [CDATA_W-1:0] codecWrData
);

  logic               ctrlHit, dataHit;
  logic               ctrlRst, ctrlEn;
  logic               cmdRead;
  logic [CREG_AW-1:0] cmdAddr;
  logic [CDATA_W-1:0] dataReg;
  logic               newIsRead;

  assign ctrlHit   = hostWrEn && (hostAddr == OFF_CTRL);
  assign cmdHit    = hostWrEn && (hostAddr == OFF_CMD);
  assign dataHit   = hostWrEn && (hostAddr == OFF_DATA);
  assign newIsRead = hostWrData[DIR_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlRst <= 1'b1;
      ctrlEn  <= 1'b0;
    end else if (ctrlHit) begin
      ctrlRst <= hostWrData[RST_BIT];
      ctrlEn  <= hostWrData[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdRead <= 1'b0;
      cmdAddr <= '0;
    end else if (strb.accept) begin
      cmdRead <= newIsRead;
      cmdAddr <= hostWrData[CREG_AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strb.zeroRead && newIsRead) begin
      dataReg <= '0;
    end else if (strb.capRead && cmdRead) begin
      dataReg <= codecRdData;
    end else if (dataHit && !strb.busy) begin
      dataReg <= hostWrData[CDATA_W-1:0];
    end
  end

  assign linkUp     = ctrlEn && !ctrlRst && linkReadyIn;
  assign linkRstOut = ctrlRst;
  assign linkEnOut  = ctrlEn && !ctrlRst;

  assign codecRnw    = cmdRead;
  assign codecAddr   = cmdAddr;
  assign codecWrData = dataReg;

  always_comb begin
    hostRdData = '0;
    if (hostAddr == OFF_CTRL) begin
      hostRdData[RST_BIT]   = ctrlRst;
      hostRdData[EN_BIT]    = ctrlEn;
      hostRdData[UP_BIT]    = linkUp;
      hostRdData[FOUND_BIT] = codecFoundIn;
      hostRdData[FAIL_BIT]  = linkFailIn;
    end else if (hostAddr == OFF_CMD) begin
      hostRdData[BUSY_BIT]      = strb.busy;
      hostRdData[DIR_BIT]       = cmdRead;
      hostRdData[CREG_AW-1:0]   = cmdAddr;
    end else if (hostAddr == OFF_DATA) begin
      hostRdData[CDATA_W-1:0]   = dataReg;
    end
  end

endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import codec_bridge_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int HDATA_W = 32,
  parameter int CREG_AW = 7,
  parameter int CDATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic               hostWrEn,
  input  logic [HDATA_W-1:0] hostWrData,
  output logic [HDATA_W-1:0] hostRdData,
  output logic               linkRstOut,
  output logic               linkEnOut,
  input  logic               linkReadyIn,
  input  logic               codecFoundIn,
  input  logic               linkFailIn,
  output logic               codecReq,
  output logic               codecRnw,
  output logic [CREG_AW-1:0] codecAddr,
  output logic [CDATA_W-1:0] codecWrData,
  input  logic               codecAck,
  input  logic [CDATA_W-1:0] codecRdData,
  output logic               linkErrPulse
);

  strobe_t strb;
  logic    cmdHit;
  logic    linkUp;
  logic    busyNow;

  assign busyNow = strb.busy;

  codec_bridge_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdHit   (cmdHit),
    .linkUp   (linkUp),
    .codecAck (codecAck),
    .strb     (strb),
    .codecReq (codecReq),
    .linkErr  (linkErrPulse)
  );

  codec_bridge_dp #(
    .ADDR_W  (ADDR_W),
    .HDATA_W (HDATA_W),
    .CREG_AW (CREG_AW),
    .CDATA_W (CDATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .hostAddr     (hostAddr),
    .hostWrEn     (hostWrEn),
    .hostWrData   (hostWrData),
    .hostRdData   (hostRdData),
    .strb         (strb),
    .codecRdData  (codecRdData),
    .linkReadyIn  (linkReadyIn),
    .codecFoundIn (codecFoundIn),
    .linkFailIn   (linkFailIn),
    .cmdHit       (cmdHit),
    .linkUp       (linkUp),
    .linkRstOut   (linkRstOut),
    .linkEnOut    (linkEnOut),
    .codecRnw     (codecRnw),
    .codecAddr    (codecAddr),
    .codecWrData  (codecWrData)
  );

endmodule

// File: rtl/codec_reg_bridge_chk.sv
module codec_reg_bridge_chk #(
  parameter int CREG_AW = 7,
  parameter int CDATA_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               codecReq,
  input logic               codecAck,
  input logic               codecRnw,
  input logic [CREG_AW-1:0] codecAddr,
  input logic [CDATA_W-1:0] codecWrData,
  input logic               busyNow,
  input logic               linkErrPulse,
  input logic               linkRstOut,
  input logic               linkEnOut
);

  // R2: an open request always reads as busy
  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    codecReq |-> busyNow);

  // R5: request held until acknowledged
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    codecReq && !codecAck |=> codecReq);

  // R5: request drops after the ack edge, busy still set for one cycle
  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    codecReq && codecAck |=> !codecReq && busyNow);

  // R3: transaction fields stable while waiting
  p_fields_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    codecReq && !codecAck |=> $stable(codecAddr) && $stable(codecRnw) && $stable(codecWrData));

  // R10: link error never coincides with a request, and lasts one cycle
  p_err_no_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    linkErrPulse |-> !codecReq && busyNow);

  p_err_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    linkErrPulse |=> !linkErrPulse && !busyNow);

  // R8: reset line dominates enable line
  p_rst_dominates_r8: assert property (@(posedge clk) disable iff (!rstN)
    linkRstOut |-> !linkEnOut);

endmodule

bind codec_reg_bridge codec_reg_bridge_chk #(
  .CREG_AW (CREG_AW),
  .CDATA_W (CDATA_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .codecReq     (codecReq),
  .codecAck     (codecAck),
  .codecRnw     (codecRnw),
  .codecAddr    (codecAddr),
  .codecWrData  (codecWrData),
  .busyNow      (busyNow),
  .linkErrPulse (linkErrPulse),
  .linkRstOut   (linkRstOut),
  .linkEnOut    (linkEnOut)
);

// File: tb/codec_reg_bridge_tb.sv
`timescale 1ns/1ps
module codec_reg_bridge_tb;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_CMD  = 8'h18;
  localparam logic [7:0] A_DATA = 8'h1C;
  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostAddr = A_CMD;
  logic        hostWrEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        linkRstOut, linkEnOut;
  logic        linkReadyIn = 1'b0, codecFoundIn = 1'b0, linkFailIn = 1'b0;
  logic        codecReq, codecRnw;
  logic [6:0]  codecAddr;
  logic [15:0] codecWrData;
  logic        codecAck = 1'b0;
  logic [15:0] codecRdData = '0;
  logic        linkErrPulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int codecTxns = 0;
  bit done = 0;

  always #5 clk = ~clk;

  codec_reg_bridge u_dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .linkRstOut(linkRstOut), .linkEnOut(linkEnOut),
    .linkReadyIn(linkReadyIn), .codecFoundIn(codecFoundIn), .linkFailIn(linkFailIn),
    .codecReq(codecReq), .codecRnw(codecRnw), .codecAddr(codecAddr),
    .codecWrData(codecWrData), .codecAck(codecAck), .codecRdData(codecRdData),
    .linkErrPulse(linkErrPulse)
  );

  // ---------------- codec model ----------------
  logic [15:0] mem [128];
  int ackCnt = 0;

  initial for (int i = 0; i < 128; i++) mem[i] = 16'hA500 | 16'(i);

  always @(negedge clk) begin
    if (!rstN) begin
      codecAck = 1'b0; ackCnt = 0;
    end else if (codecAck) begin
      codecAck = 1'b0; ackCnt = 0;
    end else if (codecReq) begin
      ackCnt++;
      if (ackCnt >= LAT) begin
        codecAck = 1'b1;
        codecRdData = mem[codecAddr];
      end
    end
  end

  always @(posedge clk) begin
    if (rstN && codecReq && codecAck) begin
      codecTxns++;
      if (!codecRnw) mem[codecAddr] <= codecWrData;
    end
  end

  // ---------------- reference model ----------------
  int   mPhase = 0;          // 0 idle, 1 waiting for codec, 2 finishing
  bit   mRst = 1, mEn = 0, mDir = 0, mErr = 0;
  int   mAddr = 0;
  int   mData = 0;

  function automatic bit mUp();
    return !mRst && mEn && linkReadyIn;
  endfunction

  function automatic logic [31:0] expRd(logic [7:0] a);
    logic [31:0] v = '0;
    if (a == A_CTRL) begin
      v[15] = mRst; v[14] = mEn; v[0] = mUp(); v[1] = codecFoundIn; v[2] = linkFailIn;
    end else if (a == A_CMD) begin
      v[15] = (mPhase != 0); v[7] = mDir; v[6:0] = 7'(mAddr);
    end else if (a == A_DATA) begin
      v[15:0] = 16'(mData);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase <= 0; mRst <= 1; mEn <= 0; mDir <= 0; mErr <= 0; mAddr <= 0; mData <= 0;
    end else begin
      mErr <= 0;
      if (hostWrEn && hostAddr == A_CTRL) begin
        mRst <= hostWrData[15]; mEn <= hostWrData[14];
      end
      if (hostWrEn && hostAddr == A_DATA && mPhase == 0) mData <= int'(hostWrData[15:0]);
      case (mPhase)
        0: if (hostWrEn && hostAddr == A_CMD) begin
             mDir  <= hostWrData[7];
             mAddr <= int'(hostWrData[6:0]);
             if (mUp()) mPhase <= 1;
             else begin
               mPhase <= 2; mErr <= 1;
               if (hostWrData[7]) mData <= 0;
             end
           end
        1: if (codecAck) begin
             mPhase <= 2;
             if (mDir) mData <= int'(codecRdData);
           end
        default: mPhase <= 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      chk("R5 codecReq", 32'(codecReq), 32'(mPhase == 1));
      chk("R10 linkErrPulse", 32'(linkErrPulse), 32'(mErr));
      chk("R8 linkRstOut", 32'(linkRstOut), 32'(mRst));
      chk("R8 linkEnOut", 32'(linkEnOut), 32'(mEn && !mRst));
      if (mPhase == 1) begin
        chk("R3 codecAddr", 32'(codecAddr), 32'(mAddr));
        chk("R3 codecRnw", 32'(codecRnw), 32'(mDir));
        if (!mDir) chk("R3 codecWrData", 32'(codecWrData), 32'(mData));
      end
      chk("R2 readback", hostRdData, expRd(hostAddr));
    end
  end

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishUp();
    end
  end

  // ---------------- host helpers ----------------
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    hostAddr = a; hostWrEn = 1'b1; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    hostAddr = a;
    #1;
    v = hostRdData;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      hostAddr = A_CMD;
      #1;
      if (!hostRdData[15]) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    int t0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl reset value", v, 32'h0000_8000);
    rd(A_CMD, v);  chk("R1 cmd reset value", v, 32'h0);
    rd(A_DATA, v); chk("R1 data reset value", v, 32'h0);
    chk("R1 codecReq low", 32'(codecReq), 32'h0);
    chk("R1 linkRstOut high", 32'(linkRstOut), 32'h1);

    // R10 command while link held in reset
    linkReadyIn = 1'b1;
    wr(A_DATA, 32'h1234);
    t0 = codecTxns;
    wr(A_CMD, 32'h85);
    chk("R10 err pulse on link-down command", 32'(linkErrPulse), 32'h1);
    rd(A_CMD, v); chk("R10 busy for one cycle", 32'(v[15]), 32'h1);
    @(negedge clk);
    rd(A_CMD, v); chk("R10 busy cleared", v, 32'h85);
    rd(A_DATA, v); chk("R10 read data zero", v, 32'h0);
    chk("R10 no codec transaction", 32'(codecTxns - t0), 32'h0);

    // R8 link control
    wr(A_CTRL, 32'hC000);
    chk("R8 reset dominates enable", 32'(linkEnOut), 32'h0);
    rd(A_CTRL, v); chk("R8 ctrl both bits", v, 32'h0000_C000);
    wr(A_CTRL, 32'h8000);
    chk("R8 reset alone holds link", 32'(linkRstOut), 32'h1);
    wr(A_CTRL, 32'h4000);
    chk("R8 enable alone raises link", 32'(linkEnOut), 32'h1);
    rd(A_CTRL, v); chk("R9 link up bit", v, 32'h0000_4001);

    // R9 status
    codecFoundIn = 1'b1;
    rd(A_CTRL, v); chk("R9 codec found bit", v, 32'h0000_4003);
    linkFailIn = 1'b1;
    rd(A_CTRL, v); chk("R9 link fail bit", v, 32'h0000_4007);
    linkFailIn = 1'b0;

    // R3 write
    wr(A_DATA, 32'hBEEF);
    t0 = codecTxns;
    wr(A_CMD, 32'h12);
    waitIdle();
    chk("R3 codec register written", 32'(mem[7'h12]), 32'hBEEF);
    chk("R3 one transaction", 32'(codecTxns - t0), 32'h1);

    // R4 reads
    wr(A_DATA, 32'h0);
    wr(A_CMD, 32'h92);
    waitIdle();
    rd(A_DATA, v); chk("R4 read back written value", v, 32'hBEEF);
    wr(A_CMD, 32'hB3);
    waitIdle();
    rd(A_DATA, v); chk("R4 read untouched register", v, 32'hA533);

    // R5 busy timing around ack
    wr(A_CMD, 32'h87);
    hostAddr = A_CMD;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #1;
      if (codecAck) break;
    end
    @(negedge clk); #1;
    chk("R5 busy held one cycle after ack", 32'(hostRdData[15]), 32'h1);
    chk("R5 request dropped after ack", 32'(codecReq), 32'h0);
    @(negedge clk); #1;
    chk("R5 busy clear two edges after ack", 32'(hostRdData[15]), 32'h0);
    rd(A_DATA, v); chk("R4 data after timed read", v, 32'hA507);

    // R6 command while busy
    t0 = codecTxns;
    wr(A_CMD, 32'hA0);
    wr(A_CMD, 32'hC4);
    waitIdle();
    rd(A_CMD, v); chk("R6 command fields kept", v, 32'hA0);
    rd(A_DATA, v); chk("R6 running read completed", v, 32'hA520);
    chk("R6 single transaction", 32'(codecTxns - t0), 32'h1);

    // R7 data write while busy
    wr(A_DATA, 32'h7777);
    wr(A_CMD, 32'h21);
    wr(A_DATA, 32'h5555);
    waitIdle();
    chk("R7 in-flight write kept data", 32'(mem[7'h21]), 32'h7777);
    rd(A_DATA, v); chk("R7 data register unchanged", v, 32'h7777);

    // R11 unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v);  chk("R11 unmapped reads zero", v, 32'h0);
    rd(8'h10, v);  chk("R11 other unmapped reads zero", v, 32'h0);
    rd(A_CTRL, v); chk("R11 ctrl untouched", v, 32'h0000_4003);
    rd(A_DATA, v); chk("R11 data untouched", v, 32'h7777);

    // R10 link down while enabled
    linkReadyIn = 1'b0;
    t0 = codecTxns;
    wr(A_CMD, 32'h92);
    chk("R10 err pulse with ready low", 32'(linkErrPulse), 32'h1);
    chk("R10 no request with ready low", 32'(codecReq), 32'h0);
    waitIdle();
    rd(A_DATA, v); chk("R10 read gives zero", v, 32'h0);
    chk("R10 codec untouched", 32'(codecTxns - t0), 32'h0);

    repeat (3) @(negedge clk);
    finishUp();
  end

endmodule